// File: doc/BRIEF.md
# Interrupt Descriptor Queue with Loss Marking

This block sits between the on-chip event sources that raise interrupts and the engine that copies interrupt descriptors out to a ring in host memory. Each cycle a source may offer one 32-bit descriptor along with its source number. A per-source suppression vector decides whether that descriptor is generated at all. Accepted descriptors wait in a first-in first-out store of configurable depth, 512 by default. They leave through a valid/ready port toward the ring writer.

The store can fill up because the host ring has no room or because the drain path lacks bandwidth. The block treats both causes the same way. A descriptor that arrives while every slot is taken and nothing leaves in that cycle is dropped. The drop is recorded by raising bit 31, the loss flag, inside the newest descriptor still held. No extra entry is added. The flag is sticky and does not count, so one raised flag stands for one or more lost descriptors. Bit 31 of every offered descriptor is cleared on entry, so the flag carries only this meaning.

The asynchronous active-low reset is synchronised inside the block before it reaches the queue state.

Top module: `irq_desc_queue`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` is low until a descriptor has been accepted.
- R2: A descriptor offered with `in_valid` high whose source bit in `src_mask` is 0 is stored. Descriptors appear on `out_desc` in arrival order, with `out_valid` high from the cycle after acceptance. Bit 31 of each stored descriptor is forced to 0, and bits 30..0 are kept unchanged.
- R3: A descriptor whose source bit in `src_mask` is 1 is not stored and leaves the output sequence unchanged.
- R4: The queue holds up to DEPTH descriptors. When DEPTH descriptors are pushed with no pops, all of them later emerge in order.
- R5: When the queue holds DEPTH entries, a descriptor arriving in a cycle without a pop is discarded and never appears on the output.
- R6: A discard sets bit 31 of the most recently stored entry and leaves every older entry unchanged. Further discards leave that entry unchanged, and the flag stays set until the entry is popped.
- R7: While the queue holds DEPTH entries, a push in the same cycle as a pop is accepted and no discard occurs.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_desc` stays stable in the next cycle.
- R9: An entry is removed only in a cycle where both `out_valid` and `out_ready` are high. Any other cycle leaves the head in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A source offers a descriptor this cycle |
| in_src | input | SRC_W (3) | Number of the offering source |
| in_desc | input | 32 | Offered descriptor word; bit 31 is ignored |
| src_mask | input | NUM_SRC (8) | Per-source suppression; 1 drops that source's descriptors |
| out_valid | output | 1 | Head descriptor available |
| out_ready | input | 1 | Ring writer takes the head this cycle |
| out_desc | output | 32 | Head descriptor; bit 31 is the loss flag |

## Verification
A wrong pointer or count shows at the ports in the very next cycle. It appears as a descriptor missing from the sequence or repeated in it, or as `out_valid` disagreeing with the number of accepted entries. A mark applied to the wrong slot stays hidden until that slot reaches the head, which can be up to DEPTH pops later. For that reason the bench fills the queue completely, forces discards and then drains every entry, comparing each head word against its reference. A wrong full decision shows as an extra or missing descriptor at the exact position of the simultaneous push and pop.

// File: rtl/irq_q_pkg.sv
package irq_q_pkg;
  localparam int unsigned DESC_W   = 32;
  localparam int unsigned LOSS_POS = DESC_W - 1;
  localparam int unsigned BODY_W   = DESC_W - 1;

  typedef logic [DESC_W-1:0] desc_t;
  typedef logic [BODY_W-1:0] body_t;
endpackage

// File: rtl/irq_q_rst_sync.sv
module irq_q_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/irq_q_gate.sv
module irq_q_gate
  import irq_q_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SRC_W   = 3
) (
  input  logic               in_valid,
  input  logic [SRC_W-1:0]   in_src,
  input  desc_t              in_desc,
  input  logic [NUM_SRC-1:0] src_mask,
  output logic               push_req,
  output body_t              push_body
);
  logic src_blocked;

  generate
    if (NUM_SRC == (1 << SRC_W)) begin : g_full_range
      assign src_blocked = src_mask[in_src];
    end else begin : g_part_range
      logic in_range;
      assign in_range    = (32'(in_src) < NUM_SRC);
      assign src_blocked = in_range ? src_mask[in_src] : 1'b1;
    end
  endgenerate

  always_comb begin
    push_req  = in_valid & ~src_blocked;
    push_body = in_desc[BODY_W-1:0];
  end
endmodule

// File: rtl/irq_q_ctrl.sv
module irq_q_ctrl #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9,
  parameter int unsigned CW    = 10
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          push_req,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic          mark_en,
  output logic [AW-1:0] mark_idx,
  output logic [AW-1:0] rd_idx
);
  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, pop_acc, push_acc, discard;

  function automatic logic [AW-1:0] idx_inc(input logic [AW-1:0] i);
    return (i == AW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [AW-1:0] idx_dec(input logic [AW-1:0] i);
    return (i == '0) ? AW'(DEPTH - 1) : i - 1'b1;
  endfunction

  always_comb begin
    full      = (cnt_q == CW'(DEPTH));
    out_valid = (cnt_q != '0);
    pop_acc   = out_valid & out_ready;
    push_acc  = push_req & (~full | pop_acc);
    discard   = push_req & full & ~pop_acc;

    wr_d  = push_acc ? idx_inc(wr_q) : wr_q;
    rd_d  = pop_acc  ? idx_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(push_acc) - CW'(pop_acc);

    wr_en    = push_acc;
    wr_idx   = wr_q;
    mark_en  = discard;
    mark_idx = idx_dec(wr_q);
    rd_idx   = rd_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_s)
    cnt_q <= CW'(DEPTH));

  assert_drop_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_s)
    discard |=> (cnt_q == $past(cnt_q)) && (wr_q == $past(wr_q)));

  assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (full && push_req && out_ready) |=> (cnt_q == CW'(DEPTH)));

  assert_idle_head_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !out_ready |=> (rd_q == $past(rd_q)));
endmodule

// File: rtl/irq_q_store.sv
module irq_q_store
  import irq_q_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  body_t         wr_body,
  input  logic          mark_en,
  input  logic [AW-1:0] mark_idx,
  input  logic [AW-1:0] rd_idx,
  output desc_t         rd_desc
);
  body_t      body_q [DEPTH];
  logic [DEPTH-1:0] lost_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      body_q[wr_idx] <= wr_body;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
      logic clr, set;
      assign clr = wr_en   && (wr_idx   == AW'(g));
      assign set = mark_en && (mark_idx == AW'(g));
      always_ff @(posedge clk) begin
        if (clr | set) begin
          lost_q[g] <= set;
        end
      end
    end
  endgenerate

  assign rd_desc = {lost_q[rd_idx], body_q[rd_idx]};
endmodule

// File: rtl/irq_desc_queue.sv
module irq_desc_queue
  import irq_q_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DEPTH   = 512
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [((NUM_SRC>1)?$clog2(NUM_SRC):1)-1:0] in_src,
  input  logic [31:0]                        in_desc,
  input  logic [NUM_SRC-1:0]                 src_mask,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [31:0]                        out_desc
);
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic          rst_s;
  logic          push_req;
  body_t         push_body;
  logic          wr_en, mark_en;
  logic [AW-1:0] wr_idx, mark_idx, rd_idx;
  desc_t         head;

  irq_q_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  irq_q_gate #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_gate (
    .in_valid  (in_valid),
    .in_src    (in_src),
    .in_desc   (in_desc),
    .src_mask  (src_mask),
    .push_req  (push_req),
    .push_body (push_body)
  );

  irq_q_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_ctrl (
    .clk       (clk),
    .rst_s     (rst_s),
    .push_req  (push_req),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .mark_en   (mark_en),
    .mark_idx  (mark_idx),
    .rd_idx    (rd_idx)
  );

  irq_q_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_body  (push_body),
    .mark_en  (mark_en),
    .mark_idx (mark_idx),
    .rd_idx   (rd_idx),
    .rd_desc  (head)
  );

  assign out_desc = head;

  initial begin
    assert_depth_min_R6: assert (DEPTH >= 2);
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_desc)));

  assert_loss_sticky_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && out_desc[LOSS_POS] && !out_ready) |=> out_desc[LOSS_POS]);
endmodule

// File: tb/test_irq_desc_queue.sv
`timescale 1ns/1ps
module test_irq_desc_queue;
  localparam int NSRC  = 8;
  localparam int DEPTH = 512;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_src;
  logic [31:0] in_desc;
  logic [7:0]  src_mask;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_desc;

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  string tag     = "R1";
  logic [31:0] mq[$];

  irq_desc_queue #(.NUM_SRC(NSRC), .DEPTH(DEPTH)) i_irq_desc_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
    .in_desc(in_desc), .src_mask(src_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_desc(out_desc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic note(input bit ok, input string req, input logic [32:0] act,
                      input logic [32:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual {valid,desc}=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare the current outputs, apply new inputs, advance the model.
  task automatic step(input bit v, input logic [2:0] s, input logic [31:0] d,
                      input bit rdy);
    bit          ev;
    logic [31:0] ed;
    bit          pop, acc;
    ev = (mq.size() > 0);
    ed = ev ? mq[0] : 32'h0;
    note((out_valid === ev) && (!ev || out_desc === ed), tag,
         {out_valid, out_desc}, {ev, ed});
    in_valid  = v;
    in_src    = s;
    in_desc   = d;
    out_ready = rdy;
    pop = ev && rdy;
    acc = v && !src_mask[s];
    if (pop) void'(mq.pop_front());
    if (acc) begin
      if (mq.size() < DEPTH) mq.push_back(d & 32'h7FFF_FFFF);
      else mq[mq.size()-1][31] = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_src = '0; in_desc = '0;
    src_mask = '0; out_ready = 1'b0;
    repeat (5) @(negedge clk);
    // R1: empty during reset
    note(out_valid === 1'b0, "R1", {out_valid, out_desc}, 33'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: empty after release
    note(out_valid === 1'b0, "R1", {out_valid, out_desc}, 33'h0);

    tag = "R2";
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 1), 3'($urandom), $urandom, $urandom_range(0, 2) != 0);

    tag = "R3";
    src_mask = 8'hA5;
    for (int i = 0; i < 200; i++)
      step(1'b1, 3'($urandom), $urandom, $urandom_range(0, 1));
    src_mask = 8'hFF;
    for (int i = 0; i < 20; i++) step(1'b1, 3'(i), 32'h1234_0000 + i, 1'b0);
    src_mask = 8'h00;
    while (mq.size() > 0) step(1'b0, 3'd0, 32'h0, 1'b1);

    tag = "R4";
    for (int i = 0; i < DEPTH; i++) step(1'b1, 3'(i), 32'hC000_0000 | i, 1'b0);

    tag = "R5";
    for (int i = 0; i < 6; i++) step(1'b1, 3'd1, 32'h0DEA_D000 + i, 1'b0);

    tag = "R7";
    for (int i = 0; i < 10; i++) step(1'b1, 3'd2, 32'h0700_0000 + i, 1'b1);

    tag = "R6";
    for (int i = 0; i < 3; i++) step(1'b1, 3'd3, 32'h0666_0000 + i, 1'b0);
    while (mq.size() > 0) step(1'b0, 3'd0, 32'h0, 1'b1);

    tag = "R8";
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 1), 3'($urandom), $urandom, $urandom_range(0, 3) == 0);

    tag = "R9";
    for (int i = 0; i < 40; i++) step(1'b0, 3'd0, 32'h0, 1'b0);
    while (mq.size() > 0) step(1'b0, 3'd0, 32'h0, 1'b1);
    step(1'b0, 3'd0, 32'h0, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule